// File: doc/BRIEF.md
# I2C Master Transfer Command Sequencer

This block turns one write of an 8-bit control word into a complete master transfer of one to four bytes on a byte-level I2C master engine. The engine below it is abstract: the sequencer asks it to issue a start with a 7-bit address, to move one byte in either direction, or to issue a stop. Each request receives one response that carries an acknowledge/success flag and, for reads, the received byte. Bit-level SCL/SDA timing belongs to that engine, not to this block.

The sequencer keeps track of whether it still owns the bus. It issues a start only when the bus is free. After each byte it releases the bus unless chaining is requested, and a forced repeated start always releases it. A halt command sent while the bus is owned issues a stop and nothing else. At the end of a sequence the block publishes the number of completed bytes, places received bytes into a four-slot buffer, updates the error, abort, has-data and full flags, and sends a one-cycle request to the interrupt logic.

States: `ST_IDLE` (waiting for a control write), `ST_ADDR` (start plus address requested), `ST_BYTE` (one data byte requested), `ST_STOP` (stop after a byte), `ST_NEXT` (decide whether another byte follows), `ST_DONE` (publish results), `ST_HALT` (stop on a halt command). Transitions: `ST_IDLE`→`ST_HALT` on a halt while the bus is owned; `ST_IDLE`→`ST_ADDR` or `ST_BYTE` on a start bit, depending on bus ownership; `ST_ADDR`→`ST_BYTE` on acknowledge or →`ST_DONE` on NACK; `ST_BYTE`→`ST_DONE` on failure, →`ST_STOP` when release is due, otherwise →`ST_NEXT`; `ST_STOP`→`ST_NEXT`; `ST_NEXT`→`ST_DONE` after the last byte, otherwise →`ST_ADDR` (bus free) or →`ST_BYTE` (bus owned); `ST_DONE`→`ST_IDLE`; `ST_HALT`→`ST_IDLE`.

Top module: `i2c_xfer_seq`

## Requirements
- R1: After reset, ctrl_q, xfer_cnt, rx_data, err, abort, has_data, full, irq_req, busy and cmd_valid are all 0, and the bus is treated as free.
- R2: A control write accepted in idle stores all eight bits except bit 0, which always reads back as 0. The control layout is: bit 0 start, bit 1 read, bit 2 chain, bit 3 forced repeated start, bits 5:4 byte count minus one, bit 6 ten-bit address mode, bit 7 halt. Bit 6 is stored but changes no behaviour.
- R3: busy rises in the cycle after an accepted start or halt write and stays high until the results are published. A control write while busy is ignored and does not change ctrl_q or start another sequence.
- R4: The command port uses cmd_op 0 for start-with-address, 1 for one data byte and 2 for stop. cmd_valid and cmd_op are held until rsp_valid is seen. Before each byte, if the bus is free, a start is issued with cmd_addr equal to dev_addr[7:1] and cmd_rnw equal to the read bit. Every start attempt clears abort. An acknowledged start clears err and takes the bus. A NACK sets err and abort and ends the sequence.
- R5: A sequence moves (bits 5:4)+1 bytes. For writes, byte i is sent as tx_data[8i+7:8i].
- R6: After a successful byte, a stop is issued and the bus released if the repeated-start bit is set or the chain bit is clear. Otherwise the bus stays owned, and the next byte, including one in a later sequence, is sent without a new start.
- R7: A failed byte sets err and abort and ends the sequence with no stop, so the bus remains owned.
- R8: When the sequence ends, xfer_cnt equals the number of bytes completed successfully (0 to 4).
- R9: On reads, a successfully received byte i is written to rx_data[8i+7:8i], and other slots keep their contents. A read sequence that completes at least one byte sets has_data. One that completes four bytes sets full. Write sequences leave both flags unchanged.
- R10: irq_req pulses for exactly one cycle, in the cycle busy falls, when at least one byte completed and irq_en and done_mask are both 1 at completion.
- R11: A halt write while the bus is owned issues only a stop, releases the bus and leaves xfer_cnt, err and abort unchanged. When the bus is free, the halt bit is ignored and the start bit runs a normal sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_wr | input | 1 | Control write strobe |
| ctrl_wdata | input | 8 | Control word being written |
| ctrl_q | output | 8 | Stored control word (bit 0 always 0) |
| dev_addr | input | 8 | Target address register; bits 7:1 are the 7-bit address |
| tx_data | input | 32 | Four outgoing bytes, byte i at bits 8i+7:8i |
| irq_en | input | 1 | Global interrupt enable |
| done_mask | input | 1 | Completion interrupt mask bit |
| cmd_valid | output | 1 | Command to the byte engine is pending |
| cmd_op | output | 2 | 0 start, 1 byte, 2 stop |
| cmd_addr | output | 7 | Address for a start command |
| cmd_rnw | output | 1 | 1 = read direction |
| cmd_wdata | output | 8 | Byte to send on a write byte command |
| rsp_valid | input | 1 | Engine response strobe for the pending command |
| rsp_ok | input | 1 | 1 = acknowledged / byte succeeded |
| rsp_rdata | input | 8 | Received byte on a read byte response |
| busy | output | 1 | Sequence in progress |
| xfer_cnt | output | 3 | Bytes completed by the last sequence |
| rx_data | output | 32 | Receive buffer, slot i at bits 8i+7:8i |
| has_data | output | 1 | Receive buffer holds data |
| full | output | 1 | Receive buffer holds four bytes |
| err | output | 1 | Error flag |
| abort | output | 1 | Transfer aborted flag |
| irq_req | output | 1 | One-cycle completion interrupt request |

## Verification
A wrong bus-ownership bit shows at the command port as soon as the next byte is due: there is either a start that should not be issued or a missing one, and a stop that is dropped or duplicated. A wrong byte index shows on cmd_wdata in the same cycle and in the rx_data slot written, both in the same sequence. A wrong completion counter or flag update shows in the cycle busy falls, as a wrong xfer_cnt, err, abort, has_data, full or irq_req value. Because the bus can stay owned across sequences, an ownership error made in one sequence can first show in the start count of the following one. The bench therefore runs sequences back to back without resetting between them.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_BYTE,
        ST_STOP,
        ST_NEXT,
        ST_DONE,
        ST_HALT
    } seq_state_t;

    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_BYTE  = 2'd1,
        OP_STOP  = 2'd2
    } bus_op_t;

    localparam int CTL_GO     = 0;
    localparam int CTL_RD     = 1;
    localparam int CTL_CHAIN  = 2;
    localparam int CTL_RSTART = 3;
    localparam int CTL_CNT_LO = 4;
    localparam int CTL_CNT_W  = 2;
    localparam int CTL_HALT   = 7;
    localparam int CTL_W      = 8;

endpackage

// File: rtl/i2c_seq_fsm.sv
module i2c_seq_fsm
    import i2c_seq_pkg::*;
#(
    parameter int SLOTS = 4,
    localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_wr,
    input  logic [CTL_W-1:0] ctrl_wdata,
    input  logic             rsp_valid,
    input  logic             rsp_ok,
    output seq_state_t       state,
    output logic [IDX_W-1:0] idx,
    output logic             rd,
    output logic             cmd_valid,
    output bus_op_t          cmd_op,
    output logic             launch,
    output logic             ev_start_try,
    output logic             ev_start_ok,
    output logic             ev_start_bad,
    output logic             ev_byte_ok,
    output logic             ev_byte_bad,
    output logic             finish
);

    seq_state_t       nxt;
    logic [IDX_W-1:0] last_idx;
    logic             chain;
    logic             rstart;
    logic             held;
    logic             halt_now;
    logic             release_due;
    logic             at_last;

    assign halt_now    = (state == ST_IDLE) && ctrl_wr && ctrl_wdata[CTL_HALT] && held;
    assign launch      = (state == ST_IDLE) && ctrl_wr && ctrl_wdata[CTL_GO] && !halt_now;
    assign release_due = rstart || !chain;
    assign at_last     = (idx == last_idx);

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (halt_now)    nxt = ST_HALT;
                else if (launch) nxt = held ? ST_BYTE : ST_ADDR;
            end
            ST_ADDR: if (rsp_valid) nxt = rsp_ok ? ST_BYTE : ST_DONE;
            ST_BYTE: begin
                if (rsp_valid) begin
                    if (!rsp_ok)          nxt = ST_DONE;
                    else if (release_due) nxt = ST_STOP;
                    else                  nxt = ST_NEXT;
                end
            end
            ST_STOP: if (rsp_valid) nxt = ST_NEXT;
            ST_NEXT: begin
                if (at_last)   nxt = ST_DONE;
                else if (held) nxt = ST_BYTE;
                else           nxt = ST_ADDR;
            end
            ST_DONE: nxt = ST_IDLE;
            ST_HALT: if (rsp_valid) nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    // state register and sequence context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            idx      <= '0;
            last_idx <= '0;
            rd       <= 1'b0;
            chain    <= 1'b0;
            rstart   <= 1'b0;
            held     <= 1'b0;
        end else begin
            state <= nxt;
            if (launch) begin
                idx      <= '0;
                last_idx <= IDX_W'(ctrl_wdata[CTL_CNT_LO +: CTL_CNT_W]);
                rd       <= ctrl_wdata[CTL_RD];
                chain    <= ctrl_wdata[CTL_CHAIN];
                rstart   <= ctrl_wdata[CTL_RSTART];
            end
            if (state == ST_ADDR && rsp_valid && rsp_ok) held <= 1'b1;
            if ((state == ST_STOP || state == ST_HALT) && rsp_valid) held <= 1'b0;
            if (state == ST_NEXT && !at_last) idx <= idx + 1'b1;
        end
    end

    // outputs
    always_comb begin
        cmd_valid    = 1'b0;
        cmd_op       = OP_START;
        ev_start_try = 1'b0;
        ev_start_ok  = 1'b0;
        ev_start_bad = 1'b0;
        ev_byte_ok   = 1'b0;
        ev_byte_bad  = 1'b0;
        finish       = 1'b0;
        unique case (state)
            ST_ADDR: begin
                cmd_valid    = 1'b1;
                cmd_op       = OP_START;
                ev_start_try = rsp_valid;
                ev_start_ok  = rsp_valid && rsp_ok;
                ev_start_bad = rsp_valid && !rsp_ok;
            end
            ST_BYTE: begin
                cmd_valid   = 1'b1;
                cmd_op      = OP_BYTE;
                ev_byte_ok  = rsp_valid && rsp_ok;
                ev_byte_bad = rsp_valid && !rsp_ok;
            end
            ST_STOP, ST_HALT: begin
                cmd_valid = 1'b1;
                cmd_op    = OP_STOP;
            end
            ST_DONE: finish = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/i2c_seq_status.sv
module i2c_seq_status
    import i2c_seq_pkg::*;
#(
    parameter int SLOTS  = 4,
    parameter int BYTE_W = 8,
    localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    localparam int CNT_W = $clog2(SLOTS + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ctrl_accept,
    input  logic [CTL_W-1:0]        ctrl_wdata,
    input  logic                    launch,
    input  logic                    rd,
    input  logic [IDX_W-1:0]        idx,
    input  logic [BYTE_W-1:0]       rsp_rdata,
    input  logic                    ev_start_try,
    input  logic                    ev_start_ok,
    input  logic                    ev_start_bad,
    input  logic                    ev_byte_ok,
    input  logic                    ev_byte_bad,
    input  logic                    finish,
    input  logic                    irq_en,
    input  logic                    done_mask,
    output logic [CTL_W-1:0]        ctrl_q,
    output logic [CNT_W-1:0]        xfer_cnt,
    output logic [SLOTS*BYTE_W-1:0] rx_data,
    output logic                    has_data,
    output logic                    full,
    output logic                    err,
    output logic                    abort,
    output logic                    irq_req
);

    logic [CNT_W-1:0] done_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            xfer_cnt <= '0;
            done_cnt <= '0;
            has_data <= 1'b0;
            full     <= 1'b0;
            err      <= 1'b0;
            abort    <= 1'b0;
            irq_req  <= 1'b0;
        end else begin
            irq_req <= 1'b0;
            if (ctrl_accept) ctrl_q <= ctrl_wdata & ~(CTL_W'(1) << CTL_GO);
            if (launch) done_cnt <= '0;
            if (ev_byte_ok) done_cnt <= done_cnt + 1'b1;
            if (ev_start_try) abort <= 1'b0;
            if (ev_start_ok) err <= 1'b0;
            if (ev_start_bad || ev_byte_bad) begin
                err   <= 1'b1;
                abort <= 1'b1;
            end
            if (finish) begin
                xfer_cnt <= done_cnt;
                if (rd && done_cnt != '0) has_data <= 1'b1;
                if (rd && done_cnt == CNT_W'(SLOTS)) full <= 1'b1;
                irq_req <= (done_cnt != '0) && irq_en && done_mask;
            end
        end
    end

    for (genvar g = 0; g < SLOTS; g++) begin : g_rx_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rx_data[g*BYTE_W +: BYTE_W] <= '0;
            end else if (ev_byte_ok && rd && idx == IDX_W'(g)) begin
                rx_data[g*BYTE_W +: BYTE_W] <= rsp_rdata;
            end
        end
    end

endmodule

// File: rtl/i2c_xfer_seq.sv
module i2c_xfer_seq
    import i2c_seq_pkg::*;
#(
    parameter int SLOTS  = 4,
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 7,
    localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    localparam int CNT_W = $clog2(SLOTS + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ctrl_wr,
    input  logic [CTL_W-1:0]        ctrl_wdata,
    output logic [CTL_W-1:0]        ctrl_q,
    input  logic [ADDR_W:0]         dev_addr,
    input  logic [SLOTS*BYTE_W-1:0] tx_data,
    input  logic                    irq_en,
    input  logic                    done_mask,
    output logic                    cmd_valid,
    output logic [1:0]              cmd_op,
    output logic [ADDR_W-1:0]       cmd_addr,
    output logic                    cmd_rnw,
    output logic [BYTE_W-1:0]       cmd_wdata,
    input  logic                    rsp_valid,
    input  logic                    rsp_ok,
    input  logic [BYTE_W-1:0]       rsp_rdata,
    output logic                    busy,
    output logic [CNT_W-1:0]        xfer_cnt,
    output logic [SLOTS*BYTE_W-1:0] rx_data,
    output logic                    has_data,
    output logic                    full,
    output logic                    err,
    output logic                    abort,
    output logic                    irq_req
);

    seq_state_t       state;
    bus_op_t          op;
    logic [IDX_W-1:0] idx;
    logic             rd;
    logic             launch;
    logic             ev_start_try;
    logic             ev_start_ok;
    logic             ev_start_bad;
    logic             ev_byte_ok;
    logic             ev_byte_bad;
    logic             finish;

    i2c_seq_fsm #(.SLOTS(SLOTS)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctrl_wr      (ctrl_wr),
        .ctrl_wdata   (ctrl_wdata),
        .rsp_valid    (rsp_valid),
        .rsp_ok       (rsp_ok),
        .state        (state),
        .idx          (idx),
        .rd           (rd),
        .cmd_valid    (cmd_valid),
        .cmd_op       (op),
        .launch       (launch),
        .ev_start_try (ev_start_try),
        .ev_start_ok  (ev_start_ok),
        .ev_start_bad (ev_start_bad),
        .ev_byte_ok   (ev_byte_ok),
        .ev_byte_bad  (ev_byte_bad),
        .finish       (finish)
    );

    i2c_seq_status #(.SLOTS(SLOTS), .BYTE_W(BYTE_W)) u_status (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctrl_accept  (ctrl_wr && !busy),
        .ctrl_wdata   (ctrl_wdata),
        .launch       (launch),
        .rd           (rd),
        .idx          (idx),
        .rsp_rdata    (rsp_rdata),
        .ev_start_try (ev_start_try),
        .ev_start_ok  (ev_start_ok),
        .ev_start_bad (ev_start_bad),
        .ev_byte_ok   (ev_byte_ok),
        .ev_byte_bad  (ev_byte_bad),
        .finish       (finish),
        .irq_en       (irq_en),
        .done_mask    (done_mask),
        .ctrl_q       (ctrl_q),
        .xfer_cnt     (xfer_cnt),
        .rx_data      (rx_data),
        .has_data     (has_data),
        .full         (full),
        .err          (err),
        .abort        (abort),
        .irq_req      (irq_req)
    );

    assign busy      = (state != ST_IDLE);
    assign cmd_op    = op;
    assign cmd_addr  = dev_addr[ADDR_W:1];
    assign cmd_rnw   = rd;
    assign cmd_wdata = tx_data[idx*BYTE_W +: BYTE_W];

endmodule

// File: rtl/i2c_seq_chk.sv
module i2c_seq_chk #(
    parameter int SLOTS = 4,
    parameter int CNT_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctrl_wr,
    input logic [7:0]       ctrl_q,
    input logic             busy,
    input logic             cmd_valid,
    input logic [1:0]       cmd_op,
    input logic             rsp_valid,
    input logic             irq_en,
    input logic             done_mask,
    input logic             irq_req,
    input logic [CNT_W-1:0] xfer_cnt,
    input logic             has_data,
    input logic             full,
    input logic             err,
    input logic             abort
);

    AST_CMD_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> busy); // R3

    AST_IGNORE_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && busy) |=> $stable(ctrl_q)); // R3

    AST_START_BIT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q[0]); // R2

    AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !rsp_valid) |=> (cmd_valid && $stable(cmd_op))); // R4

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_cnt <= CNT_W'(SLOTS)); // R8

    AST_ERR_WITH_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> abort); // R7

    AST_FULL_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> has_data); // R9

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> ($past(irq_en) && $past(done_mask) && xfer_cnt != '0)); // R10

    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |=> !irq_req); // R10

endmodule

bind i2c_xfer_seq i2c_seq_chk #(.SLOTS(SLOTS), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_wr   (ctrl_wr),
    .ctrl_q    (ctrl_q),
    .busy      (busy),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .rsp_valid (rsp_valid),
    .irq_en    (irq_en),
    .done_mask (done_mask),
    .irq_req   (irq_req),
    .xfer_cnt  (xfer_cnt),
    .has_data  (has_data),
    .full      (full),
    .err       (err),
    .abort     (abort)
);

// File: tb/i2c_xfer_seq_bench.sv
module i2c_xfer_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctrl_wr = 1'b0;
    logic [7:0]  ctrl_wdata = '0;
    logic [7:0]  ctrl_q;
    logic [7:0]  dev_addr = 8'h00;
    logic [31:0] tx_data = 32'h0;
    logic        irq_en = 1'b0;
    logic        done_mask = 1'b0;
    logic        cmd_valid;
    logic [1:0]  cmd_op;
    logic [6:0]  cmd_addr;
    logic        cmd_rnw;
    logic [7:0]  cmd_wdata;
    logic        rsp_valid = 1'b0;
    logic        rsp_ok = 1'b0;
    logic [7:0]  rsp_rdata = '0;
    logic        busy;
    logic [2:0]  xfer_cnt;
    logic [31:0] rx_data;
    logic        has_data, full, err, abort, irq_req;

    always #4 clk = ~clk; // 125 MHz

    i2c_xfer_seq u_i2c_xfer_seq (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
        .ctrl_q(ctrl_q), .dev_addr(dev_addr), .tx_data(tx_data),
        .irq_en(irq_en), .done_mask(done_mask), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_rnw(cmd_rnw),
        .cmd_wdata(cmd_wdata), .rsp_valid(rsp_valid), .rsp_ok(rsp_ok),
        .rsp_rdata(rsp_rdata), .busy(busy), .xfer_cnt(xfer_cnt),
        .rx_data(rx_data), .has_data(has_data), .full(full), .err(err),
        .abort(abort), .irq_req(irq_req)
    );

    int total = 0;
    int bad = 0;

    // engine model state
    int       n_start, n_byte, n_stop, cur_byte, side_bad;
    bit       sl_nack;
    int       sl_fail;
    logic [7:0] sl_seed;
    bit       sl_rd;

    // expectation model state
    bit         m_held = 0, m_err = 0, m_abort = 0, m_has = 0, m_full = 0;
    int         m_cnt = 0;
    logic [7:0] m_ctrl = '0;
    logic [7:0] m_rx [4];

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    // byte-level engine responder
    initial begin
        forever begin
            @(negedge clk);
            if (cmd_valid) begin
                rsp_valid = 1'b1;
                rsp_ok    = 1'b1;
                case (cmd_op)
                    2'd0: begin
                        n_start++;
                        if (cmd_addr != dev_addr[7:1] || cmd_rnw != sl_rd) side_bad++;
                        rsp_ok = !sl_nack;
                    end
                    2'd1: begin
                        n_byte++;
                        if (!sl_rd && cmd_wdata != tx_data[cur_byte*8 +: 8]) side_bad++;
                        rsp_ok    = (cur_byte != sl_fail);
                        rsp_rdata = sl_seed + 8'(cur_byte);
                        cur_byte++;
                    end
                    default: n_stop++;
                endcase
            end else begin
                rsp_valid = 1'b0;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: run did not end act=hung exp=done");
        summary();
        $finish;
    end

    // one control write plus the expectation model for it
    task automatic run(input logic [7:0] cv, input bit nack, input int fail_at,
                       input bit en, input bit msk, input bit poke);
        int e_st = 0, e_by = 0, e_sp = 0, cnt = 0;
        bit e_irq = 0;
        bit h = m_held;
        int prev_cnt = m_cnt;
        irq_en = en; done_mask = msk;
        n_start = 0; n_byte = 0; n_stop = 0; cur_byte = 0; side_bad = 0;
        sl_nack = nack; sl_fail = fail_at; sl_rd = cv[1];
        sl_seed = 8'h30 + cv;
        m_ctrl = cv & 8'hFE;
        if (cv[7] && h) begin
            e_sp = 1; h = 0;
        end else if (cv[0]) begin
            for (int i = 0; i <= int'(cv[5:4]); i++) begin
                if (!h) begin
                    e_st++; m_abort = 0;
                    if (nack) begin m_err = 1; m_abort = 1; break; end
                    m_err = 0; h = 1;
                end
                e_by++;
                if (i == fail_at) begin m_err = 1; m_abort = 1; break; end
                if (cv[1]) m_rx[i] = sl_seed + 8'(i);
                cnt++;
                if (cv[3] || !cv[2]) begin e_sp++; h = 0; end
            end
            m_cnt = cnt;
            if (cv[1] && cnt > 0) m_has = 1;
            if (cv[1] && cnt == 4) m_full = 1;
            e_irq = (cnt > 0) && en && msk;
        end
        m_held = h;
        @(negedge clk);
        ctrl_wr = 1'b1; ctrl_wdata = cv;
        @(negedge clk);
        ctrl_wr = 1'b0;
        if (poke && busy) begin
            ctrl_wr = 1'b1; ctrl_wdata = 8'hF3;
            @(negedge clk);
            ctrl_wr = 1'b0;
        end
        while (busy) @(negedge clk);
        check("R4 start count",     n_start, e_st);
        check("R5 byte count",      n_byte, e_by);
        check("R6 stop count",      n_stop, e_sp);
        check("R4 R5 bus fields",   side_bad, 0);
        check("R8 xfer_cnt",        xfer_cnt, (cv[7] && e_sp == 1 && !cv[0]) || e_sp == 1 && e_by == 0 ? prev_cnt : m_cnt);
        check("R7 err",             err, m_err);
        check("R7 abort",           abort, m_abort);
        check("R9 has_data",        has_data, m_has);
        check("R9 full",            full, m_full);
        check("R9 rx_data",         rx_data, {m_rx[3], m_rx[2], m_rx[1], m_rx[0]});
        check("R10 irq_req",        irq_req, e_irq);
        check("R2 ctrl_q",          ctrl_q, m_ctrl);
        @(negedge clk);
        check("R10 irq one cycle",  irq_req, 0);
    endtask

    initial begin
        for (int k = 0; k < 4; k++) m_rx[k] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 ctrl_q",   ctrl_q, 0);
        check("R1 busy",     busy, 0);
        check("R1 cmd",      cmd_valid, 0);
        check("R1 xfer_cnt", xfer_cnt, 0);
        check("R1 flags",    {err, abort, has_data, full, irq_req}, 0);
        check("R1 rx_data",  rx_data, 0);

        // sweep over count, direction, chain, repeated start and fault placement
        for (int len = 0; len < 4; len++)
            for (int dir = 0; dir < 2; dir++)
                for (int ch = 0; ch < 2; ch++)
                    for (int rp = 0; rp < 2; rp++)
                        for (int f = 0; f < len + 3; f++) begin
                            logic [7:0] cv;
                            cv = {1'b0, 1'(ch ^ rp), 2'(len), 1'(rp), 1'(ch), 1'(dir), 1'b1};
                            dev_addr = 8'(8'h5A + len * 16 + f * 2);
                            tx_data  = 32'hC3A5_1E00 ^ {24'h0, 8'(len * 8 + f)};
                            run(cv, f == 1, f >= 2 ? f - 2 : 99, (f % 2) == 0, ((f + len) % 3) != 0, 1'b0);
                        end

        // R3: control write during a sequence is ignored
        run(8'h31, 1'b0, 99, 1'b1, 1'b1, 1'b1);
        // R11: own the bus, then halt while owned
        run(8'h05, 1'b0, 99, 1'b1, 1'b1, 1'b0);
        check("R6 bus kept after chain", m_held, 1);
        run(8'h81, 1'b0, 99, 1'b1, 1'b1, 1'b0);
        // R11: halt with bus free runs a normal sequence
        run(8'h81, 1'b0, 99, 1'b1, 1'b1, 1'b0);
        // R11: halt only, bus free: nothing happens
        run(8'h80, 1'b0, 99, 1'b1, 1'b1, 1'b0);

        summary();
        $finish;
    end

endmodule